// File: doc/BRIEF.md
# SPI Host Command and Data Register Front End

This block sits between a processor's 32-bit register bus and a command-driven SPI engine. Software writes 16-bit engine commands and outgoing bytes into two push windows. It collects incoming bytes through a pop window and a non-destructive peek window. Each window is backed by its own FIFO. Software paces its traffic with free-space and fill-level registers. An interrupt controller raises a registered level output when a FIFO is nearly drained, nearly full, or when the engine reports a synchronisation marker.

The engine side has three streams. Command words and outgoing bytes leave on valid/ready outputs. A word moves on any clock edge where both valid and ready are high. The output holds its word and keeps valid high until the engine takes it. Incoming bytes arrive on a valid/ready input. The block lowers ready while its receive FIFO is full, so the engine must hold the byte until ready returns. A soft-reset register holds the engine and all three FIFOs in reset while it reads 1.

Top module: `spi_host_regfront`

## Requirements
- R1: Offset 0x00 reads a constant identification word: major number in bits 23:16 (always 1), minor in 15:8, patch in 7:0, bits 31:24 zero.
- R2: A write to 0xE0 queues bits 15:0 as a command. Commands leave on `cmd_data` in write order, and one is removed on each edge with `cmd_valid` and `cmd_ready` both high.
- R3: A write to 0xE4 queues bits 7:0 as an outgoing byte. Bytes leave on `tx_data` in write order under the same valid/ready rule.
- R4: A read of 0xE8 returns the oldest received byte and removes it. A read of 0xEC returns the same byte and leaves the FIFO unchanged.
- R5: Offsets 0xD0 and 0xD4 read the free entries of the command and outgoing FIFOs. Offset 0xD8 reads the number of stored received bytes.
- R6: A push into a full FIFO is discarded. A pop or peek of an empty receive FIFO returns 0. Neither case moves any FIFO state.
- R7: Writing bit 0 of 0x40 as 1 drives `engine_rst` high, empties all FIFOs, removes all stream valids and readies, and ignores bus pushes. Writing 0 releases it. Offset 0x40 reads the current bit.
- R8: Pending bits (0x84) are set on each edge where their source is true: bit 0 when command FIFO level is at most a quarter of its depth; bit 1 likewise for the outgoing FIFO; bit 2 when receive level is at least three quarters of its depth; bit 3 when `sync_valid` is high.
- R9: Writing 1 to a pending bit clears it. If its source is still true on that edge, the bit stays set.
- R10: On `sync_valid`, `sync_id` is captured and offset 0xC0 reads the last captured value (0 after reset).
- R11: Offset 0x80 holds a 4-bit enable mask and 0x88 reads pending AND enable. `irq` is high one cycle after any enabled pending bit is set.
- R12: `rx_ready` is low while the receive FIFO holds its full depth. A byte offered then is not stored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe |
| bus_addr | input | 8 | Byte offset of the access |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid the cycle after `bus_rd` |
| cmd_valid | output | 1 | Command word available |
| cmd_ready | input | 1 | Engine accepts the command word |
| cmd_data | output | 16 | Oldest command word |
| tx_valid | output | 1 | Outgoing byte available |
| tx_ready | input | 1 | Engine accepts the outgoing byte |
| tx_data | output | 8 | Oldest outgoing byte |
| rx_valid | input | 1 | Engine offers a received byte |
| rx_ready | output | 1 | Receive FIFO can store a byte |
| rx_data | input | 8 | Received byte |
| sync_valid | input | 1 | Engine reports a sync marker this cycle |
| sync_id | input | 8 | Identifier of that marker |
| engine_rst | output | 1 | Soft reset held for the engine |
| irq | output | 1 | Registered interrupt level |

## Verification
Results follow a stimulus at fixed delays:
- Read data is due one cycle after the read strobe.
- A push or stream transfer shows on valid, ready, head and the counters one cycle after its edge.
- A pending bit is set one cycle after its source.
- `irq` follows the pending bit one cycle later still.

The bench keeps a behavioural model that advances on the same edge as the design. It compares every observable output at the falling edge, half a cycle after the registers update. Read data is compared only on cycles that follow a read, against the value the model computed from its state before that edge.

// File: rtl/rf_pkg.sv
package rf_pkg;
  localparam int ADDR_W  = 8;
  localparam int BUS_W   = 32;
  localparam int CMD_W   = 16;
  localparam int BYTE_W  = 8;
  localparam int IRQ_N   = 4;

  localparam logic [7:0] VER_MAJOR = 8'd1;

  localparam logic [ADDR_W-1:0] A_IDENT    = 8'h00;
  localparam logic [ADDR_W-1:0] A_SOFTRST  = 8'h40;
  localparam logic [ADDR_W-1:0] A_IRQ_EN   = 8'h80;
  localparam logic [ADDR_W-1:0] A_IRQ_PEND = 8'h84;
  localparam logic [ADDR_W-1:0] A_IRQ_SRC  = 8'h88;
  localparam logic [ADDR_W-1:0] A_SYNC     = 8'hC0;
  localparam logic [ADDR_W-1:0] A_CMD_ROOM = 8'hD0;
  localparam logic [ADDR_W-1:0] A_TX_ROOM  = 8'hD4;
  localparam logic [ADDR_W-1:0] A_RX_LVL   = 8'hD8;
  localparam logic [ADDR_W-1:0] A_CMD_PUSH = 8'hE0;
  localparam logic [ADDR_W-1:0] A_TX_PUSH  = 8'hE4;
  localparam logic [ADDR_W-1:0] A_RX_POP   = 8'hE8;
  localparam logic [ADDR_W-1:0] A_RX_PEEK  = 8'hEC;

  // interrupt bit positions
  localparam int IB_CMD_LOW  = 0;
  localparam int IB_TX_LOW   = 1;
  localparam int IB_RX_HIGH  = 2;
  localparam int IB_SYNC     = 3;
endpackage

// File: rtl/rf_fifo.sv
module rf_fifo #(
  parameter int W     = 8,
  parameter int DEPTH = 16,
  localparam int PW   = $clog2(DEPTH),
  localparam int LW   = PW + 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          flush,
  input  logic          push,
  input  logic [W-1:0]  push_data,
  input  logic          pop,
  output logic [W-1:0]  head,
  output logic [LW-1:0] level,
  output logic          full,
  output logic          empty
);
  logic [W-1:0]  mem [DEPTH];
  logic [PW-1:0] wr_ptr, rd_ptr;
  logic [LW-1:0] cnt;
  logic          do_push, do_pop;

  assign full    = (cnt == LW'(DEPTH));
  assign empty   = (cnt == '0);
  assign do_push = push && !full && !flush;
  assign do_pop  = pop && !empty && !flush;
  assign level   = cnt;
  assign head    = empty ? '0 : mem[rd_ptr];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      cnt    <= '0;
    end else if (flush) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      cnt    <= '0;
    end else begin
      if (do_push) wr_ptr <= wr_ptr + PW'(1);
      if (do_pop)  rd_ptr <= rd_ptr + PW'(1);
      case ({do_push, do_pop})
        2'b10:   cnt <= cnt + LW'(1);
        2'b01:   cnt <= cnt - LW'(1);
        default: cnt <= cnt;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (do_push) mem[wr_ptr] <= push_data;
  end
endmodule

// File: rtl/rf_irq_ctrl.sv
module rf_irq_ctrl #(
  parameter int N = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] src,
  input  logic         en_wr,
  input  logic         clr_wr,
  input  logic [N-1:0] wdata,
  output logic [N-1:0] pend,
  output logic [N-1:0] en,
  output logic         irq
);
  logic [N-1:0] clr_mask;
  assign clr_mask = clr_wr ? wdata : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend <= '0;
      en   <= '0;
      irq  <= 1'b0;
    end else begin
      // a source that is true on the clearing edge wins
      pend <= (pend & ~clr_mask) | src;
      if (en_wr) en <= wdata;
      irq  <= |(pend & en);
    end
  end
endmodule

// File: rtl/spi_host_regfront.sv
module spi_host_regfront
  import rf_pkg::*;
#(
  parameter int CMD_DEPTH = 16,
  parameter int TX_DEPTH  = 16,
  parameter int RX_DEPTH  = 16,
  parameter logic [7:0] VER_MINOR = 8'h02,
  parameter logic [7:0] VER_PATCH = 8'h00
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [BUS_W-1:0]  bus_wdata,
  output logic [BUS_W-1:0]  bus_rdata,
  output logic              cmd_valid,
  input  logic              cmd_ready,
  output logic [CMD_W-1:0]  cmd_data,
  output logic              tx_valid,
  input  logic              tx_ready,
  output logic [BYTE_W-1:0] tx_data,
  input  logic              rx_valid,
  output logic              rx_ready,
  input  logic [BYTE_W-1:0] rx_data,
  input  logic              sync_valid,
  input  logic [BYTE_W-1:0] sync_id,
  output logic              engine_rst,
  output logic              irq
);
  localparam int CMD_LW = $clog2(CMD_DEPTH) + 1;
  localparam int TX_LW  = $clog2(TX_DEPTH) + 1;
  localparam int RX_LW  = $clog2(RX_DEPTH) + 1;
  localparam int CMD_LO = CMD_DEPTH / 4;
  localparam int TX_LO  = TX_DEPTH / 4;
  localparam int RX_HI  = (3 * RX_DEPTH) / 4;
  localparam logic [BUS_W-1:0] IDENT_WORD = {8'h00, VER_MAJOR, VER_MINOR, VER_PATCH};

  logic              soft_rst_q;
  logic [BYTE_W-1:0] sync_id_q;
  logic [BUS_W-1:0]  rdata_q, rd_mux;

  logic              cmd_empty, cmd_full, tx_empty, tx_full, rx_empty, rx_full;
  logic [CMD_LW-1:0] cmd_level;
  logic [TX_LW-1:0]  tx_level;
  logic [RX_LW-1:0]  rx_level;
  logic [BYTE_W-1:0] rx_head;
  logic [IRQ_N-1:0]  irq_src, irq_pend, irq_en;

  logic wr_softrst, wr_en, wr_pend, wr_cmd, wr_tx, rd_pop;
  assign wr_softrst = bus_wr && (bus_addr == A_SOFTRST);
  assign wr_en      = bus_wr && (bus_addr == A_IRQ_EN);
  assign wr_pend    = bus_wr && (bus_addr == A_IRQ_PEND);
  assign wr_cmd     = bus_wr && (bus_addr == A_CMD_PUSH) && !soft_rst_q;
  assign wr_tx      = bus_wr && (bus_addr == A_TX_PUSH) && !soft_rst_q;
  assign rd_pop     = bus_rd && (bus_addr == A_RX_POP) && !soft_rst_q;

  rf_fifo #(.W(CMD_W), .DEPTH(CMD_DEPTH)) u_cmd_fifo (
    .clk(clk), .rst_n(rst_n), .flush(soft_rst_q),
    .push(wr_cmd), .push_data(bus_wdata[CMD_W-1:0]),
    .pop(cmd_valid && cmd_ready), .head(cmd_data),
    .level(cmd_level), .full(cmd_full), .empty(cmd_empty)
  );

  rf_fifo #(.W(BYTE_W), .DEPTH(TX_DEPTH)) u_tx_fifo (
    .clk(clk), .rst_n(rst_n), .flush(soft_rst_q),
    .push(wr_tx), .push_data(bus_wdata[BYTE_W-1:0]),
    .pop(tx_valid && tx_ready), .head(tx_data),
    .level(tx_level), .full(tx_full), .empty(tx_empty)
  );

  rf_fifo #(.W(BYTE_W), .DEPTH(RX_DEPTH)) u_rx_fifo (
    .clk(clk), .rst_n(rst_n), .flush(soft_rst_q),
    .push(rx_valid && rx_ready), .push_data(rx_data),
    .pop(rd_pop), .head(rx_head),
    .level(rx_level), .full(rx_full), .empty(rx_empty)
  );

  assign cmd_valid  = !cmd_empty && !soft_rst_q;
  assign tx_valid   = !tx_empty && !soft_rst_q;
  assign rx_ready   = !rx_full && !soft_rst_q;
  assign engine_rst = soft_rst_q;

  always_comb begin
    irq_src              = '0;
    irq_src[IB_CMD_LOW]  = (int'(cmd_level) <= CMD_LO);
    irq_src[IB_TX_LOW]   = (int'(tx_level) <= TX_LO);
    irq_src[IB_RX_HIGH]  = (int'(rx_level) >= RX_HI);
    irq_src[IB_SYNC]     = sync_valid;
  end

  rf_irq_ctrl #(.N(IRQ_N)) u_irq (
    .clk(clk), .rst_n(rst_n), .src(irq_src),
    .en_wr(wr_en), .clr_wr(wr_pend), .wdata(bus_wdata[IRQ_N-1:0]),
    .pend(irq_pend), .en(irq_en), .irq(irq)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      soft_rst_q <= 1'b0;
      sync_id_q  <= '0;
    end else begin
      if (wr_softrst) soft_rst_q <= bus_wdata[0];
      if (sync_valid) sync_id_q  <= sync_id;
    end
  end

  always_comb begin
    case (bus_addr)
      A_IDENT:    rd_mux = IDENT_WORD;
      A_SOFTRST:  rd_mux = BUS_W'(soft_rst_q);
      A_IRQ_EN:   rd_mux = BUS_W'(irq_en);
      A_IRQ_PEND: rd_mux = BUS_W'(irq_pend);
      A_IRQ_SRC:  rd_mux = BUS_W'(irq_pend & irq_en);
      A_SYNC:     rd_mux = BUS_W'(sync_id_q);
      A_CMD_ROOM: rd_mux = BUS_W'(CMD_DEPTH) - BUS_W'(cmd_level);
      A_TX_ROOM:  rd_mux = BUS_W'(TX_DEPTH) - BUS_W'(tx_level);
      A_RX_LVL:   rd_mux = BUS_W'(rx_level);
      A_RX_POP,
      A_RX_PEEK:  rd_mux = BUS_W'(rx_head);
      default:    rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      rdata_q <= '0;
    else if (bus_rd) rdata_q <= rd_mux;
  end
  assign bus_rdata = rdata_q;
endmodule

// File: rtl/rf_checks.sv
module rf_checks #(
  parameter int RX_DEPTH = 16,
  localparam int RX_LW = $clog2(RX_DEPTH) + 1
) (
  input logic             clk,
  input logic             rst_n,
  input logic             bus_wr,
  input logic [7:0]       bus_addr,
  input logic [31:0]      bus_wdata,
  input logic             cmd_valid,
  input logic             cmd_ready,
  input logic [15:0]      cmd_data,
  input logic             tx_valid,
  input logic             rx_ready,
  input logic             engine_rst,
  input logic             sync_valid,
  input logic             irq,
  input logic [3:0]       pend,
  input logic [3:0]       en,
  input logic [RX_LW-1:0] rx_level
);
  assert_irq_rise_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (|(pend & en)) |=> irq);

  assert_irq_quiet_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !(|(pend & en)) |=> !irq);

  assert_cmd_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && !cmd_ready && !(bus_wr && bus_addr == 8'h40 && bus_wdata[0]))
      |=> (cmd_valid && $stable(cmd_data)));

  assert_softrst_quiet_R7: assert property (@(posedge clk) disable iff (!rst_n)
    engine_rst |-> (!cmd_valid && !tx_valid && !rx_ready));

  assert_sync_clear_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_addr == 8'h84 && bus_wdata[3] && !sync_valid) |=> !pend[3]);

  assert_no_overflow_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (int'(rx_level) <= RX_DEPTH));

  assert_full_stall_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (int'(rx_level) == RX_DEPTH) |-> !rx_ready);
endmodule

bind spi_host_regfront rf_checks #(.RX_DEPTH(RX_DEPTH)) u_rf_checks (
  .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
  .bus_wdata(bus_wdata), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
  .cmd_data(cmd_data), .tx_valid(tx_valid), .rx_ready(rx_ready),
  .engine_rst(engine_rst), .sync_valid(sync_valid), .irq(irq),
  .pend(irq_pend), .en(irq_en), .rx_level(rx_level)
);

// File: tb/test_spi_host_regfront.sv
`timescale 1ns/1ps
module test_spi_host_regfront;
  localparam int D = 16;
  localparam logic [31:0] IDENT = 32'h0001_0200;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic bus_wr = 0, bus_rd = 0;
  logic [7:0] bus_addr = 0;
  logic [31:0] bus_wdata = 0;
  logic [31:0] bus_rdata;
  logic cmd_valid, cmd_ready = 0;
  logic [15:0] cmd_data;
  logic tx_valid, tx_ready = 0;
  logic [7:0] tx_data;
  logic rx_valid = 0, rx_ready;
  logic [7:0] rx_data = 0;
  logic sync_valid = 0;
  logic [7:0] sync_id = 0;
  logic engine_rst, irq;

  always #2 clk = ~clk;

  spi_host_regfront i_spi_host_regfront (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .cmd_valid(cmd_valid), .cmd_ready(cmd_ready), .cmd_data(cmd_data),
    .tx_valid(tx_valid), .tx_ready(tx_ready), .tx_data(tx_data),
    .rx_valid(rx_valid), .rx_ready(rx_ready), .rx_data(rx_data),
    .sync_valid(sync_valid), .sync_id(sync_id),
    .engine_rst(engine_rst), .irq(irq)
  );

  int total = 0, failed = 0;
  bit done = 0;

  // reference model state
  logic [15:0] cq[$];
  logic [7:0]  tq[$], rq[$];
  logic [3:0]  m_pend = 0, m_en = 0;
  logic        m_srst = 0, m_irq = 0, m_rflag = 0;
  logic [7:0]  m_sid = 0;
  logic [31:0] m_rdata = 0;
  string       m_rtag = "";

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      failed++;
      $display("FAIL %s: actual %h expected %h at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic logic [31:0] mread(input logic [7:0] a, output string tag);
    case (a)
      8'h00: begin tag = "R1 ident";         mread = IDENT; end
      8'h40: begin tag = "R7 softreset";     mread = 32'(m_srst); end
      8'h80: begin tag = "R11 enable";       mread = 32'(m_en); end
      8'h84: begin tag = "R8 R9 pending";    mread = 32'(m_pend); end
      8'h88: begin tag = "R11 source";       mread = 32'(m_pend & m_en); end
      8'hC0: begin tag = "R10 sync id";      mread = 32'(m_sid); end
      8'hD0: begin tag = (cq.size() == D) ? "R6 cmd full room" : "R5 cmd room";
                   mread = 32'(D - cq.size()); end
      8'hD4: begin tag = (tq.size() == D) ? "R6 tx full room" : "R5 tx room";
                   mread = 32'(D - tq.size()); end
      8'hD8: begin tag = "R5 rx level";      mread = 32'(rq.size()); end
      8'hE8, 8'hEC: begin
        tag = (rq.size() == 0) ? "R6 empty rx read" : "R4 rx read";
        mread = (rq.size() == 0) ? 32'h0 : 32'(rq[0]);
      end
      default: begin tag = "R1 unmapped"; mread = 32'h0; end
    endcase
  endfunction

  always @(posedge clk) begin : model
    int csz, tsz, rsz;
    logic [3:0] src, clr;
    logic nirq;
    if (!rst_n) begin
      cq.delete(); tq.delete(); rq.delete();
      m_pend = 0; m_en = 0; m_srst = 0; m_irq = 0; m_rflag = 0; m_sid = 0; m_rdata = 0;
    end else begin
      csz = cq.size(); tsz = tq.size(); rsz = rq.size();
      m_rflag = bus_rd;
      if (bus_rd) m_rdata = mread(bus_addr, m_rtag);
      nirq = |(m_pend & m_en);
      src = {sync_valid, rsz >= 12, tsz <= 4, csz <= 4};
      clr = (bus_wr && bus_addr == 8'h84) ? bus_wdata[3:0] : 4'h0;
      m_pend = (m_pend & ~clr) | src;
      if (bus_wr && bus_addr == 8'h80) m_en = bus_wdata[3:0];
      if (m_srst) begin
        cq.delete(); tq.delete(); rq.delete();
      end else begin
        if (csz > 0 && cmd_ready) void'(cq.pop_front());
        if (bus_wr && bus_addr == 8'hE0 && csz < D) cq.push_back(bus_wdata[15:0]);
        if (tsz > 0 && tx_ready) void'(tq.pop_front());
        if (bus_wr && bus_addr == 8'hE4 && tsz < D) tq.push_back(bus_wdata[7:0]);
        if (rx_valid && rsz < D) rq.push_back(rx_data);
        if (bus_rd && bus_addr == 8'hE8 && rsz > 0) void'(rq.pop_front());
      end
      if (bus_wr && bus_addr == 8'h40) m_srst = bus_wdata[0];
      if (sync_valid) m_sid = sync_id;
      m_irq = nirq;
    end
  end

  always @(negedge clk) begin
    if (rst_n && !done) begin
      chk(cmd_valid === (cq.size() > 0 && !m_srst), "R2 cmd_valid", 32'(cmd_valid), 32'(cq.size() > 0 && !m_srst));
      if (cq.size() > 0 && !m_srst) chk(cmd_data === cq[0], "R2 cmd_data", 32'(cmd_data), 32'(cq[0]));
      chk(tx_valid === (tq.size() > 0 && !m_srst), "R3 tx_valid", 32'(tx_valid), 32'(tq.size() > 0 && !m_srst));
      if (tq.size() > 0 && !m_srst) chk(tx_data === tq[0], "R3 tx_data", 32'(tx_data), 32'(tq[0]));
      chk(rx_ready === (rq.size() < D && !m_srst), "R12 rx_ready", 32'(rx_ready), 32'(rq.size() < D && !m_srst));
      chk(engine_rst === m_srst, "R7 engine_rst", 32'(engine_rst), 32'(m_srst));
      chk(irq === m_irq, "R11 irq", 32'(irq), 32'(m_irq));
      if (m_rflag) chk(bus_rdata === m_rdata, m_rtag, bus_rdata, m_rdata);
    end
  end

  task automatic tick();
    @(negedge clk); #1;
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    bus_wr = 1; bus_addr = a; bus_wdata = d; tick(); bus_wr = 0;
  endtask

  task automatic rd(input logic [7:0] a);
    bus_rd = 1; bus_addr = a; tick(); bus_rd = 0;
  endtask

  task automatic summary();
    $display("%0d/%0d checks passed", total - failed, total);
  endtask

  initial begin
    repeat (3) tick();
    rst_n = 1;
    tick();
    // reset state and identification (R1, R5, R10, R11)
    rd(8'h00); rd(8'h40); rd(8'h80); rd(8'h84); rd(8'h88);
    rd(8'hC0); rd(8'hD0); rd(8'hD4); rd(8'hD8); rd(8'h10);
    // enable and level sources (R8, R11)
    wr(8'h80, 32'hF); tick(); tick(); rd(8'h84); rd(8'h88);
    wr(8'h84, 32'hFF); rd(8'h84);           // R9 reassert
    // fill command FIFO past full (R2, R6)
    for (int i = 0; i < 20; i++) wr(8'hE0, 32'h1000 + i);
    rd(8'hD0); wr(8'h84, 32'h1); rd(8'h84);
    for (int i = 0; i < 6; i++) wr(8'hE4, 32'hA0 + i);
    rd(8'hD4);
    cmd_ready = 1; repeat (8) tick(); cmd_ready = 0; rd(8'hD0);
    wr(8'h84, 32'h3); rd(8'h84);
    for (int i = 0; i < 12; i++) begin tx_ready = i[0]; tick(); end
    tx_ready = 0;
    // receive path with back-pressure (R4, R12)
    rx_valid = 1;
    for (int i = 0; i < 18; i++) begin rx_data = 8'h30 + 8'(i); tick(); end
    rx_valid = 0;
    rd(8'hD8); rd(8'hEC); rd(8'hEC);
    for (int i = 0; i < 4; i++) rd(8'hE8);
    rd(8'hD8); rd(8'h84);
    for (int i = 0; i < 12; i++) rd(8'hE8);
    rd(8'hE8); rd(8'hEC); rd(8'hD8);        // R6 empty pops
    // sync marker (R10)
    sync_valid = 1; sync_id = 8'h5A; tick(); sync_valid = 0; tick();
    rd(8'hC0); rd(8'h84); wr(8'h84, 32'h8); rd(8'h84);
    wr(8'h80, 32'h8); tick(); rd(8'h88);
    wr(8'h80, 32'h0); tick(); tick(); rd(8'h88);
    // soft reset (R7)
    wr(8'hE0, 32'h0BAD); wr(8'hE0, 32'h0C0D); wr(8'hE4, 32'h77);
    rx_valid = 1; rx_data = 8'h99; tick(); rx_valid = 0;
    wr(8'h40, 32'h1); rd(8'h40);
    wr(8'hE0, 32'hBEEF); wr(8'hE4, 32'h55);
    rx_valid = 1; tick(); rx_valid = 0;
    cmd_ready = 1; tick(); cmd_ready = 0;
    rd(8'hD0); rd(8'hD4); rd(8'hD8); rd(8'hE8);
    wr(8'h40, 32'h0); rd(8'h40);
    wr(8'hE0, 32'h4242); rd(8'hD0);
    cmd_ready = 1; repeat (3) tick(); cmd_ready = 0;
    tick();
    done = 1;
    summary();
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      total++; failed++;
      $display("FAIL R2 watchdog: actual %0d expected %0d", 0, 1);
      done = 1;
      summary();
      $finish;
    end
  end
endmodule